// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block decides, each time the core raises a request strobe, how the processor enters a handler. There are four outcomes: a synchronous exception, an external interrupt, a forced reset, or no entry at all. Its inputs are the pending exception code, an interrupt-pending flag, and the code and level of the winning interrupt source. It also takes the current program counter, status word, vector base, stack register r15, a delay-slot flag and a halt-wake flag.

When an entry is taken, all architectural state changes commit on the clock edge that samples the strobe. The saved return address, saved status and saved stack pointer are written. The status word is updated, the event code registers are loaded, and the program counter moves to the handler address. An acknowledge pulse and two flag-clear pulses are driven combinationally in the strobe cycle, so the core can drop its delay-slot and wake flags on the same edge.

Status word bit positions used throughout: BL (block) is bit 28, RB (bank) is bit 29, MD (privilege) is bit 30, and the interrupt mask is bits 7:4.

Top module: `trap_entry_seq`

## Requirements
- R1: When `req` is high and `exc_valid` is high, an exception or reset is taken and any pending interrupt is ignored: INTEVT keeps its value and the new PC is not the interrupt vector.
- R2: When `exc_valid` is high while SR bit 28 (BL) is set, any exception code other than 0x1E0 becomes a reset. EXPEVT becomes 0x000, PC becomes 0xA0000000 and SR bits 7:4 become 0xF.
- R3: Exception code 0x1E0 raised while BL is set is taken as an ordinary exception: EXPEVT becomes 0x1E0 and PC becomes VBR+0x100.
- R4: With BL set and no exception, a pending interrupt is not taken unless `halt_wake` is high. In that case `wake_clr` pulses in the same cycle, and the interrupt is taken if its level qualifies.
- R5: An interrupt is taken only if `irq_level` is strictly greater than SR bits 7:4. Otherwise `ack` stays low and no output register changes.
- R6: On every entry, SSR receives the current SR and SGR receives r15. The new SR is the old SR with bits 28, 29 and 30 set and all other bits kept, except for the reset case of R2.
- R7: If `in_slot` is high on an entry, SPC is PC−2 and `slot_clr` pulses in that cycle. Otherwise SPC is PC.
- R8: For exception code 0x160, SPC is the return address of R7 plus 2.
- R9: An interrupt writes `irq_code` to INTEVT and sets PC to VBR+0x600, leaving EXPEVT unchanged.
- R10: Exception codes 0x040 and 0x060 set PC to VBR+0x400. Every other non-reset exception sets PC to VBR+0x100. EXPEVT receives the code.
- R11: `ack` is high in the strobe cycle exactly when an entry is taken. The registers change on that clock edge. Without `req`, nothing changes and no pulse is driven.
- R12: After reset, PC is 0xA0000000, SR is 0x700000F0, and SPC, SSR, SGR, EXPEVT and INTEVT are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Evaluate-and-commit strobe |
| exc_valid | input | 1 | A synchronous exception is pending |
| exc_code | input | 12 | Pending exception code |
| irq_pend | input | 1 | Interrupt controller reports a pending source |
| irq_code | input | 12 | Code of the winning interrupt source |
| irq_level | input | 4 | Priority level of the winning source |
| halt_wake | input | 1 | Core is waking from a halt state |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 32 | Current status word |
| vbr | input | 32 | Vector base |
| r15 | input | 32 | Current stack register |
| in_slot | input | 1 | Faulting instruction sits in a delay slot |
| ack | output | 1 | Entry taken this cycle |
| wake_clr | output | 1 | Clear the halt-wake flag |
| slot_clr | output | 1 | Clear the delay-slot flags |
| new_pc | output | 32 | Handler address after entry |
| new_sr | output | 32 | Status word after entry |
| spc | output | 32 | Saved return address |
| ssr | output | 32 | Saved status word |
| sgr | output | 32 | Saved r15 |
| expevt | output | 12 | Last exception event code |
| intevt | output | 12 | Last interrupt event code |

## Verification
The assertions assume that all request inputs are stable from just after one clock edge through the next edge. They also assume that `req` is low while reset is held, so the registered results can be related to the inputs of the previous cycle. The bench drives every input at the falling edge and holds `req` low during reset. Its random phase draws exception codes from a small set that includes the trap, the TLB-miss codes and 0x1E0, and it sets BL, the mask and `halt_wake` often enough to reach every branch of the arbitration.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  typedef enum logic [1:0] {
    ENT_NONE  = 2'd0,
    ENT_EXC   = 2'd1,
    ENT_RESET = 2'd2,
    ENT_IRQ   = 2'd3
  } entry_e;

  // status word field positions
  localparam int SR_BL      = 28;
  localparam int SR_RB      = 29;
  localparam int SR_MD      = 30;
  localparam int SR_MASK_LO = 4;
  localparam int SR_MASK_W  = 4;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_entry_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int LVL_W = 4,
  parameter logic [CODE_W-1:0] BLOCK_OK_CODE = 12'h1E0,
  parameter logic [CODE_W-1:0] RESET_CODE = 12'h000
) (
  input  logic              req,
  input  logic              blocked,
  input  logic [LVL_W-1:0]  imask,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_pend,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              halt_wake,
  output entry_e            kind,
  output logic [CODE_W-1:0] code_eff,
  output logic              wake_use
);
  always_comb begin
    kind     = ENT_NONE;
    code_eff = exc_code;
    wake_use = 1'b0;
    if (req) begin
      if (exc_valid) begin
        if (blocked && exc_code != BLOCK_OK_CODE) begin
          kind     = ENT_RESET;
          code_eff = RESET_CODE;
        end else begin
          kind = ENT_EXC;
        end
      end else if (irq_pend) begin
        wake_use = blocked && halt_wake;
        if ((!blocked || halt_wake) && irq_level > imask) kind = ENT_IRQ;
      end
    end
  end
endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CODE_W = 12,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hA000_0000,
  parameter logic [XLEN-1:0] OFS_GEN = 32'h100,
  parameter logic [XLEN-1:0] OFS_TLB = 32'h400,
  parameter logic [XLEN-1:0] OFS_IRQ = 32'h600,
  parameter logic [CODE_W-1:0] TRAP_CODE = 12'h160,
  parameter logic [CODE_W-1:0] TLB_RD_CODE = 12'h040,
  parameter logic [CODE_W-1:0] TLB_WR_CODE = 12'h060
) (
  input  entry_e            kind,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   vbr,
  input  logic              in_slot,
  output logic [XLEN-1:0]   tgt_pc,
  output logic [XLEN-1:0]   ret_pc,
  output logic [XLEN-1:0]   nxt_sr
);
  localparam logic [XLEN-1:0] SLOT_STEP = XLEN'(2);

  function automatic logic [XLEN-1:0] return_addr(
    input logic [XLEN-1:0] pc, input logic slot, input logic is_trap);
    logic [XLEN-1:0] r;
    r = slot ? pc - SLOT_STEP : pc;
    if (is_trap) r = r + SLOT_STEP;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] vector_addr(
    input entry_e k, input logic [CODE_W-1:0] c, input logic [XLEN-1:0] base);
    case (k)
      ENT_RESET: return RESET_VEC;
      ENT_IRQ:   return base + OFS_IRQ;
      default:   return (c == TLB_RD_CODE || c == TLB_WR_CODE) ?
                        base + OFS_TLB : base + OFS_GEN;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] entry_sr(
    input entry_e k, input logic [XLEN-1:0] sr);
    logic [XLEN-1:0] s;
    s = sr;
    s[SR_BL] = 1'b1;
    s[SR_MD] = 1'b1;
    s[SR_RB] = 1'b1;
    if (k == ENT_RESET) s[SR_MASK_LO +: SR_MASK_W] = '1;
    return s;
  endfunction

  always_comb begin
    ret_pc = return_addr(cur_pc, in_slot, kind == ENT_EXC && code == TRAP_CODE);
    tgt_pc = vector_addr(kind, code, vbr);
    nxt_sr = entry_sr(kind, cur_sr);
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CODE_W = 12,
  parameter int LVL_W = 4,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hA000_0000,
  parameter logic [XLEN-1:0] RESET_SR = 32'h7000_00F0,
  parameter logic [CODE_W-1:0] BLOCK_OK_CODE = 12'h1E0,
  parameter logic [CODE_W-1:0] RESET_CODE = 12'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_pend,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              halt_wake,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   vbr,
  input  logic [XLEN-1:0]   r15,
  input  logic              in_slot,
  output logic              ack,
  output logic              wake_clr,
  output logic              slot_clr,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   new_sr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   sgr,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt
);
  entry_e            kind_w;
  logic [CODE_W-1:0] code_w;
  logic              wake_w;
  logic [XLEN-1:0]   tgt_pc_w, ret_pc_w, nxt_sr_w;
  logic              blocked_w;
  logic [LVL_W-1:0]  imask_w;
  logic              take_w;

  assign blocked_w = cur_sr[SR_BL];
  assign imask_w   = cur_sr[SR_MASK_LO +: LVL_W];

  trap_arbiter #(
    .CODE_W(CODE_W), .LVL_W(LVL_W),
    .BLOCK_OK_CODE(BLOCK_OK_CODE), .RESET_CODE(RESET_CODE)
  ) u_arb (
    .req(req & rst_n), .blocked(blocked_w), .imask(imask_w),
    .exc_valid(exc_valid), .exc_code(exc_code),
    .irq_pend(irq_pend), .irq_level(irq_level), .halt_wake(halt_wake),
    .kind(kind_w), .code_eff(code_w), .wake_use(wake_w)
  );

  trap_target #(
    .XLEN(XLEN), .CODE_W(CODE_W), .RESET_VEC(RESET_VEC)
  ) u_tgt (
    .kind(kind_w), .code(code_w), .cur_pc(cur_pc), .cur_sr(cur_sr),
    .vbr(vbr), .in_slot(in_slot),
    .tgt_pc(tgt_pc_w), .ret_pc(ret_pc_w), .nxt_sr(nxt_sr_w)
  );

  assign take_w   = (kind_w != ENT_NONE);
  assign ack      = take_w;
  assign wake_clr = wake_w;
  assign slot_clr = take_w & in_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_pc <= RESET_VEC;
      new_sr <= RESET_SR;
      spc    <= '0;
      ssr    <= '0;
      sgr    <= '0;
      expevt <= '0;
      intevt <= '0;
    end else if (take_w) begin
      new_pc <= tgt_pc_w;
      new_sr <= nxt_sr_w;
      spc    <= ret_pc_w;
      ssr    <= cur_sr;
      sgr    <= r15;
      if (kind_w == ENT_IRQ) intevt <= irq_code;
      else                   expevt <= code_w;
    end
  end

  // R1: an exception request never resolves to an interrupt entry
  assert_exc_beats_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req && exc_valid) |-> (ack && $past(1'b1) && kind_w != ENT_IRQ));

  // R2: exception while blocked (not the allowed code) lands at the reset vector
  assert_blocked_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && exc_valid && cur_sr[SR_BL] && exc_code != BLOCK_OK_CODE)
      |=> (new_pc == RESET_VEC && expevt == RESET_CODE
           && new_sr[SR_MASK_LO +: LVL_W] == '1));

  // R4: blocked interrupt without wake is refused
  assert_blocked_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !exc_valid && cur_sr[SR_BL] && !halt_wake) |-> !ack);

  // R5: interrupt at or below the mask is refused
  assert_mask_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !exc_valid && irq_level <= cur_sr[SR_MASK_LO +: LVL_W]) |-> !ack);

  // R6: entry saves status and stack and raises BL, MD, RB
  assert_entry_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (ssr == $past(cur_sr) && sgr == $past(r15)
             && new_sr[SR_BL] && new_sr[SR_MD] && new_sr[SR_RB]));

  // R11: without an entry the architectural registers hold
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ($stable(new_pc) && $stable(new_sr) && $stable(spc)
              && $stable(expevt) && $stable(intevt)));

  // R7: slot clear only accompanies an entry
  assert_slot_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_clr |-> (ack && in_slot));
endmodule

// File: tb/tb_trap_entry_seq.sv
module tb_trap_entry_seq;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, exc_valid = 1'b0, irq_pend = 1'b0, halt_wake = 1'b0, in_slot = 1'b0;
  logic [11:0] exc_code = '0, irq_code = '0;
  logic [3:0]  irq_level = '0;
  logic [31:0] cur_pc = '0, cur_sr = '0, vbr = '0, r15 = '0;
  logic        ack, wake_clr, slot_clr;
  logic [31:0] new_pc, new_sr, spc, ssr, sgr;
  logic [11:0] expevt, intevt;

  trap_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .req(req), .exc_valid(exc_valid), .exc_code(exc_code),
    .irq_pend(irq_pend), .irq_code(irq_code), .irq_level(irq_level),
    .halt_wake(halt_wake), .cur_pc(cur_pc), .cur_sr(cur_sr), .vbr(vbr), .r15(r15),
    .in_slot(in_slot), .ack(ack), .wake_clr(wake_clr), .slot_clr(slot_clr),
    .new_pc(new_pc), .new_sr(new_sr), .spc(spc), .ssr(ssr), .sgr(sgr),
    .expevt(expevt), .intevt(intevt)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_pc = 32'hA000_0000, m_sr = 32'h7000_00F0, m_spc = '0, m_ssr = '0, m_sgr = '0;
  logic [11:0] m_exp = '0, m_int = '0;
  string prev_tag = "R12";

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%08h exp=%08h", tag, what, got, exp);
    end
  endtask

  task automatic cmp_regs(input string tag);
    chk(tag, "new_pc", new_pc, m_pc);
    chk(tag, "new_sr", new_sr, m_sr);
    chk(tag, "spc", spc, m_spc);
    chk(tag, "ssr", ssr, m_ssr);
    chk(tag, "sgr", sgr, m_sgr);
    chk(tag, "expevt", {20'd0, expevt}, {20'd0, m_exp});
    chk(tag, "intevt", {20'd0, intevt}, {20'd0, m_int});
  endtask

  // one evaluation: compare last results, drive, check pulses, advance model
  task automatic step(input string tag, input logic rq, input logic ev, input logic [11:0] ec,
                      input logic ip, input logic [11:0] ic, input logic [3:0] il,
                      input logic hw, input logic [31:0] pc, input logic [31:0] sr,
                      input logic [31:0] vb, input logic [31:0] r, input logic sl);
    int kind;
    logic wk;
    @(negedge clk);
    cmp_regs(prev_tag);
    req = rq; exc_valid = ev; exc_code = ec; irq_pend = ip; irq_code = ic;
    irq_level = il; halt_wake = hw; cur_pc = pc; cur_sr = sr; vbr = vb; r15 = r; in_slot = sl;
    #1;
    kind = 0; wk = 1'b0;
    if (rq && ev) kind = (sr[28] && ec != 12'h1E0) ? 2 : 1;
    else if (rq && ip) begin
      wk = sr[28] && hw;
      if ((!sr[28] || hw) && il > sr[7:4]) kind = 3;
    end
    chk(tag, "ack", {31'd0, ack}, {31'd0, kind != 0});
    chk(tag, "wake_clr", {31'd0, wake_clr}, {31'd0, wk});
    chk(tag, "slot_clr", {31'd0, slot_clr}, {31'd0, (kind != 0) && sl});
    if (kind != 0) begin
      m_ssr = sr;
      m_sgr = r;
      m_spc = sl ? pc - 32'd2 : pc;
      if (kind == 1 && ec == 12'h160) m_spc = m_spc + 32'd2;
      m_sr = sr | 32'h7000_0000;
      if (kind == 2) begin
        m_sr[7:4] = 4'hF;
        m_pc = 32'hA000_0000;
        m_exp = 12'h000;
      end else if (kind == 3) begin
        m_pc = vb + 32'h600;
        m_int = ic;
      end else begin
        m_pc = (ec == 12'h040 || ec == 12'h060) ? vb + 32'h400 : vb + 32'h100;
        m_exp = ec;
      end
    end
    prev_tag = tag;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state compared at the first step
    step("R10", 1, 1, 12'h0A0, 0, 12'h0, 4'h0, 0, 32'h0C00_1000, 32'h0000_0000, 32'h8C00_0000, 32'h1111_0000, 0);
    step("R10", 1, 1, 12'h040, 0, 12'h0, 4'h0, 0, 32'h0C00_2000, 32'h0000_0000, 32'h8C00_0000, 32'h2222_0000, 0);
    step("R10", 1, 1, 12'h060, 0, 12'h0, 4'h0, 0, 32'h0C00_2004, 32'h0000_0000, 32'h8D00_0000, 32'h2222_0004, 0);
    step("R1",  1, 1, 12'h180, 1, 12'h320, 4'hF, 0, 32'h0C00_3000, 32'h0000_0000, 32'h8C00_0000, 32'h3333_0000, 0);
    step("R2",  1, 1, 12'h0A0, 0, 12'h0, 4'h0, 0, 32'h0C00_4000, 32'h1000_0030, 32'h8C00_0000, 32'h4444_0000, 0);
    step("R3",  1, 1, 12'h1E0, 0, 12'h0, 4'h0, 0, 32'h0C00_5000, 32'h1000_0030, 32'h8C00_0000, 32'h5555_0000, 0);
    step("R4",  1, 0, 12'h0, 1, 12'h200, 4'hE, 0, 32'h0C00_6000, 32'h1000_0000, 32'h8C00_0000, 32'h6666_0000, 0);
    step("R4",  1, 0, 12'h0, 1, 12'h220, 4'hE, 1, 32'h0C00_6100, 32'h1000_0000, 32'h8C00_0000, 32'h6666_0100, 0);
    step("R5",  1, 0, 12'h0, 1, 12'h240, 4'h5, 0, 32'h0C00_7000, 32'h0000_0050, 32'h8C00_0000, 32'h7777_0000, 0);
    step("R9",  1, 0, 12'h0, 1, 12'h260, 4'h6, 0, 32'h0C00_7100, 32'h0000_0050, 32'h8E00_0000, 32'h7777_0100, 0);
    step("R7",  1, 1, 12'h0E0, 0, 12'h0, 4'h0, 0, 32'h0C00_8002, 32'h0000_0000, 32'h8C00_0000, 32'h8888_0000, 1);
    step("R8",  1, 1, 12'h160, 0, 12'h0, 4'h0, 0, 32'h0C00_9000, 32'h0000_0000, 32'h8C00_0000, 32'h9999_0000, 0);
    step("R8",  1, 1, 12'h160, 0, 12'h0, 4'h0, 0, 32'h0C00_9102, 32'h0000_0000, 32'h8C00_0000, 32'h9999_0100, 1);
    step("R11", 0, 1, 12'h0A0, 1, 12'h300, 4'hF, 1, 32'h0C00_A000, 32'h0000_0000, 32'h8F00_0000, 32'hAAAA_0000, 1);
    step("R6",  1, 1, 12'h120, 0, 12'h0, 4'h0, 0, 32'h0C00_B000, 32'h0A5A_3C03, 32'h8C00_0000, 32'hBBBB_0000, 0);
    for (int i = 0; i < 400; i++) begin
      logic [11:0] c;
      logic [31:0] s;
      case ($urandom % 7)
        0: c = 12'h040; 1: c = 12'h060; 2: c = 12'h160; 3: c = 12'h1E0;
        4: c = 12'h0A0; 5: c = 12'h100; default: c = 12'h0C0;
      endcase
      s = $urandom;
      s[28] = ($urandom % 3) == 0;
      step("R11", ($urandom % 5) != 0, ($urandom % 3) == 0, c, $urandom % 2 == 0,
           12'h200 + 12'($urandom % 16) * 12'h20, 4'($urandom), $urandom % 2 == 1,
           $urandom & 32'hFFFF_FFFE, s, $urandom & 32'hFFFF_F000, $urandom, $urandom % 4 == 0);
    end
    step("R11", 0, 0, 12'h0, 0, 12'h0, 4'h0, 0, 32'h0, 32'h0, 32'h0, 32'h0, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule